// File: doc/BRIEF.md
# Modulo Pointer Address Generator

This block produces the 8-bit word address for accesses to two independent 256-word data memories. Each memory has its own group of four 8-bit pointer registers. An access names a group, one pointer in it and a 2-bit update mode. The address presented to the memory is the chosen pointer exactly as it stood before the access. At the next clock edge the pointer is rewritten with its updated value.

The update modes are: hold, plain post-increment, and circular post-decrement or post-increment over a power-of-two window. A 3-bit size input `n` sets the window. Only the low `n` bits of the pointer move and wrap. The upper bits stay where they are, so a pointer can walk a ring buffer placed anywhere on a 2^n boundary.

A separate load port writes any pointer directly. The memories and the instruction decode that drives the access fields sit outside this block.

Top module: `modptr_agen`

## Requirements
- R1: After reset every pointer in both groups reads as 0.
- R2: `ram_addr` shows the pointer chosen by `acc_bank`/`acc_sel` combinationally, in the same cycle as the access. This is the value before any update.
- R3: With `acc_mode` = 0 (hold), an access leaves the pointer unchanged.
- R4: With `acc_mode` = 1 (step), the pointer becomes old+1 modulo 256, whatever the value of `loop_size`.
- R5: With `acc_mode` = 3 (ring up) and `loop_size` = n ≠ 0, with mask M = 2^n−1, the new value is (old & ~M) | ((old+1) & M).
- R6: With `acc_mode` = 2 (ring down) and `loop_size` = n ≠ 0, the new value is (old & ~M) | ((old−1) & M).
- R7: With `loop_size` = 0, mode 3 gives old+1 and mode 2 gives old−1, both modulo 256.
- R8: When `ld_en` is high, the named pointer takes `ld_data` at the next edge. This load overrides an access update of the same pointer in the same cycle. An access to a different pointer in that cycle still updates its own pointer.
- R9: An access or load changes only the pointer it names. Every other pointer in both groups keeps its value.
- R10: While `acc_valid` is low, no pointer changes, whatever the mode and size inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access happens this cycle |
| acc_bank | input | 1 | Group / memory select for the access |
| acc_sel | input | 2 | Pointer within the group |
| acc_mode | input | 2 | 0 hold, 1 step, 2 ring down, 3 ring up |
| loop_size | input | 3 | Ring window is 2^loop_size words; 0 means no ring |
| ram_addr | output | 8 | Word address for the access (the pointer before update) |
| ld_en | input | 1 | Direct pointer load |
| ld_bank | input | 1 | Group of the pointer to load |
| ld_sel | input | 2 | Pointer within the group to load |
| ld_data | input | 8 | Value to load |

## Verification
Some properties are checked on every cycle by assertions:
- the step arithmetic of the update unit, including that ring modes keep the bits above the window;
- that a load lands in its register, and that it wins over a same-register access;
- that untouched registers and idle cycles leave the state stable.

Other behaviour shows only in the bench scenarios. These are the exact wrapped values at the top and bottom of each window size, across all 256 start values and all modes, and the absence of interference between the two groups. Load collisions against a different register are also covered there.

// File: rtl/modptr_pkg.sv
package modptr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_STEP    = 2'd1,
        MODE_RING_DN = 2'd2,
        MODE_RING_UP = 2'd3
    } ptr_mode_e;

endpackage

// File: rtl/modptr_step.sv
module modptr_step
    import modptr_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int SIZE_W = 3
) (
    input  logic [PTR_W-1:0]  cur,
    input  ptr_mode_e         mode,
    input  logic [SIZE_W-1:0] ring_log2,
    output logic [PTR_W-1:0]  nxt
);

    localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    logic [PTR_W-1:0] win_mask;
    logic [PTR_W-1:0] plus_one;
    logic [PTR_W-1:0] minus_one;
    logic             ring_off;

    always_comb begin
        win_mask  = (ONE << ring_log2) - ONE;
        plus_one  = cur + ONE;
        minus_one = cur - ONE;
        ring_off  = (ring_log2 == '0);
        unique case (mode)
            MODE_HOLD:    nxt = cur;
            MODE_STEP:    nxt = plus_one;
            MODE_RING_DN: nxt = ring_off ? minus_one
                                         : ((cur & ~win_mask) | (minus_one & win_mask));
            MODE_RING_UP: nxt = ring_off ? plus_one
                                         : ((cur & ~win_mask) | (plus_one & win_mask));
            default:      nxt = cur;
        endcase
    end

    always_comb begin
        if (mode == MODE_STEP) begin
            assert_step_plain_R4: assert (PTR_W'(nxt - cur) == ONE)
                else $error("step mode did not advance by one");
        end
        if ((mode == MODE_RING_UP || mode == MODE_RING_DN) && ring_log2 != '0) begin
            assert_ring_high_fixed_R5: assert (((nxt ^ cur) >> ring_log2) == '0)
                else $error("ring mode disturbed bits above the window");
        end
        if (mode == MODE_RING_UP && ring_log2 == '0) begin
            assert_ring_zero_up_R7: assert (PTR_W'(nxt - cur) == ONE)
                else $error("size zero ring-up is not a plain increment");
        end
        if (mode == MODE_RING_DN && ring_log2 == '0) begin
            assert_ring_zero_dn_R7: assert (PTR_W'(cur - nxt) == ONE)
                else $error("size zero ring-down is not a plain decrement");
        end
    end

endmodule

// File: rtl/modptr_bank.sv
module modptr_bank #(
    parameter int NPTR  = 4,
    parameter int PTR_W = 8,
    localparam int SEL_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [SEL_W-1:0] upd_sel,
    input  logic [PTR_W-1:0] upd_val,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [PTR_W-1:0] wr_data,
    output logic [PTR_W-1:0] ptr_o [NPTR]
);

    typedef struct packed {
        logic [NPTR-1:0][PTR_W-1:0] ptr;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NPTR; i++) begin
            if (wr_en && wr_sel == SEL_W'(i)) begin
                st_d.ptr[i] = wr_data;
            end else if (upd_en && upd_sel == SEL_W'(i)) begin
                st_d.ptr[i] = upd_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NPTR; g++) begin : g_out
        assign ptr_o[g] = st_q.ptr[g];

        assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SEL_W'(g)) |=> (st_q.ptr[g] == $past(wr_data)))
            else $error("direct load not captured");

        assert_untouched_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_en && wr_sel == SEL_W'(g)) && !(upd_en && upd_sel == SEL_W'(g)))
            |=> $stable(st_q.ptr[g]))
            else $error("unaddressed pointer changed");
    end

endmodule

// File: rtl/modptr_agen.sv
module modptr_agen
    import modptr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic [0:0] acc_bank,
    input  logic [1:0] acc_sel,
    input  logic [1:0] acc_mode,
    input  logic [2:0] loop_size,
    output logic [7:0] ram_addr,
    input  logic       ld_en,
    input  logic [0:0] ld_bank,
    input  logic [1:0] ld_sel,
    input  logic [7:0] ld_data
);

    localparam int NUM_BANKS = 2;
    localparam int NPTR      = 4;
    localparam int PTR_W     = 8;
    localparam int SIZE_W    = 3;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int SEL_W     = $clog2(NPTR);
    localparam int ALL_W     = NUM_BANKS * NPTR * PTR_W;

    logic [PTR_W-1:0] bank_ptrs [NUM_BANKS][NPTR];
    logic [PTR_W-1:0] cur_ptr;
    logic [PTR_W-1:0] next_ptr;
    logic [ALL_W-1:0] all_ptrs;
    ptr_mode_e        mode_e;

    assign mode_e   = ptr_mode_e'(acc_mode);
    assign cur_ptr  = bank_ptrs[acc_bank][acc_sel];
    assign ram_addr = cur_ptr;

    modptr_step #(
        .PTR_W  (PTR_W),
        .SIZE_W (SIZE_W)
    ) u_step (
        .cur       (cur_ptr),
        .mode      (mode_e),
        .ring_log2 (loop_size),
        .nxt       (next_ptr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic upd_hit;
        logic wr_hit;
        assign upd_hit = acc_valid && (acc_bank == BANK_W'(b));
        assign wr_hit  = ld_en && (ld_bank == BANK_W'(b));

        modptr_bank #(
            .NPTR  (NPTR),
            .PTR_W (PTR_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_en  (upd_hit),
            .upd_sel (acc_sel[SEL_W-1:0]),
            .upd_val (next_ptr),
            .wr_en   (wr_hit),
            .wr_sel  (ld_sel[SEL_W-1:0]),
            .wr_data (ld_data),
            .ptr_o   (bank_ptrs[b])
        );

        for (genvar p = 0; p < NPTR; p++) begin : g_flat
            assign all_ptrs[(b*NPTR+p)*PTR_W +: PTR_W] = bank_ptrs[b][p];
        end
    end

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !ld_en) |=> $stable(all_ptrs))
        else $error("pointer state changed on an idle cycle");

    assert_hold_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_mode == 2'd0 && !ld_en) |=> $stable(all_ptrs))
        else $error("hold access altered pointer state");

endmodule

// File: tb/tb_modptr_agen.sv
`timescale 1ns/1ps
module tb_modptr_agen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_valid;
    logic [0:0] acc_bank;
    logic [1:0] acc_sel;
    logic [1:0] acc_mode;
    logic [2:0] loop_size;
    logic [7:0] ram_addr;
    logic       ld_en;
    logic [0:0] ld_bank;
    logic [1:0] ld_sel;
    logic [7:0] ld_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0] mdl [2][4];

    always #4 clk = ~clk;

    modptr_agen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_bank  (acc_bank),
        .acc_sel   (acc_sel),
        .acc_mode  (acc_mode),
        .loop_size (loop_size),
        .ram_addr  (ram_addr),
        .ld_en     (ld_en),
        .ld_bank   (ld_bank),
        .ld_sel    (ld_sel),
        .ld_data   (ld_data)
    );

    function automatic logic [7:0] model_next(logic [7:0] v, int m, int n);
        int w;
        int lo;
        w  = 1 << n;
        lo = v % w;
        case (m)
            0: return v;
            1: return 8'((v + 1) % 256);
            2: return (n == 0) ? 8'((v + 255) % 256) : 8'(v - lo + ((lo + w - 1) % w));
            default: return (n == 0) ? 8'((v + 1) % 256) : 8'(v - lo + ((lo + 1) % w));
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic read_all(string req);
        acc_valid = 1'b0;
        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < 4; s++) begin
                acc_bank = 1'(b);
                acc_sel  = 2'(s);
                #1;
                chk(req, ram_addr, mdl[b][s]);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_bank = '0; acc_sel = '0;
        acc_mode = '0; loop_size = '0; ld_en = 1'b0; ld_bank = '0;
        ld_sel = '0; ld_data = '0;
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 4; s++) mdl[b][s] = 8'd0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state of all eight pointers
        read_all("R1");

        // Sweep all sizes, modes and start values
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 4; m++) begin
                for (int v = 0; v < 256; v++) begin
                    int b;
                    int s;
                    string tag;
                    b = v % 2;
                    s = (v / 2) % 4;
                    ld_en = 1'b1; ld_bank = 1'(b); ld_sel = 2'(s); ld_data = 8'(v);
                    tick();
                    ld_en = 1'b0;
                    mdl[b][s] = 8'(v);
                    acc_valid = 1'b1; acc_bank = 1'(b); acc_sel = 2'(s);
                    acc_mode = 2'(m); loop_size = 3'(n);
                    #1;
                    chk("R2", ram_addr, v);
                    tick();
                    acc_valid = 1'b0;
                    mdl[b][s] = model_next(8'(v), m, n);
                    #1;
                    if (m == 0)      tag = "R3";
                    else if (m == 1) tag = "R4";
                    else if (n == 0) tag = "R7";
                    else if (m == 3) tag = "R5";
                    else             tag = "R6";
                    chk(tag, ram_addr, mdl[b][s]);
                    if (v % 64 == 63) read_all("R9");
                end
            end
        end

        // R10: idle cycles with active-looking mode fields change nothing
        acc_valid = 1'b0; acc_mode = 2'd1; loop_size = 3'd3;
        acc_bank = 1'b1; acc_sel = 2'd2;
        repeat (4) tick();
        read_all("R10");

        // R8: load and access hit the same pointer; load wins
        ld_en = 1'b1; ld_bank = 1'b0; ld_sel = 2'd1; ld_data = 8'h5A;
        acc_valid = 1'b1; acc_bank = 1'b0; acc_sel = 2'd1; acc_mode = 2'd1; loop_size = 3'd0;
        tick();
        ld_en = 1'b0; acc_valid = 1'b0;
        mdl[0][1] = 8'h5A;
        read_all("R8");

        // R8: load and access on different pointers both take effect
        ld_en = 1'b1; ld_bank = 1'b1; ld_sel = 2'd3; ld_data = 8'hC3;
        acc_valid = 1'b1; acc_bank = 1'b0; acc_sel = 2'd1; acc_mode = 2'd3; loop_size = 3'd2;
        tick();
        ld_en = 1'b0; acc_valid = 1'b0;
        mdl[1][3] = 8'hC3;
        mdl[0][1] = model_next(8'h5A, 3, 2);
        read_all("R8");

        // R5/R6 at window edges: 0x5F ring up size 4 -> 0x50; 0x50 ring down -> 0x5F
        ld_en = 1'b1; ld_bank = 1'b1; ld_sel = 2'd0; ld_data = 8'h5F;
        tick();
        ld_en = 1'b0;
        acc_valid = 1'b1; acc_bank = 1'b1; acc_sel = 2'd0; acc_mode = 2'd3; loop_size = 3'd4;
        tick();
        acc_valid = 1'b0;
        #1;
        chk("R5", ram_addr, 8'h50);
        acc_valid = 1'b1; acc_mode = 2'd2;
        tick();
        acc_valid = 1'b0;
        #1;
        chk("R6", ram_addr, 8'h5F);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule